// File: doc/BRIEF.md
# Two-Argument Arctangent Operand Preparation Stage

This block sits ahead of the divider and arctangent core of a single-precision atan2 unit. It takes a y operand and an x operand (y is the second source, x the first, so the unit computes atan2(y, x)) together with a mode bit. The mode bit selects a result in radians or a result already divided by pi. Each operand is classified as NaN, infinity, zero, subnormal or normal. Every IEEE special case, including signed zeros and infinities, is resolved here and its final 32-bit result is produced directly.

For finite nonzero operands the block does not compute anything transcendental. It picks the quotient whose magnitude is at most one: numerator over denominator, either y/x or x/y. It also picks an additive offset constant and a bit that says whether the core's arctangent term is subtracted from that offset. The downstream core then evaluates `offset + atan(num/den)` or `offset - atan(num/den)`. The offset is added as a separate output term, so no significance is lost next to a term bounded by pi/2.

Inputs and outputs use valid/ready handshakes. The output set is registered one cycle after acceptance and held while the consumer stalls.

Top module: `atan2_prep`

## Requirements
- R1: An input is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its outputs appear with `out_valid` high after that edge. `in_ready` is high exactly when no output is pending or `out_ready` is high. A pending output with `out_ready` high and no new acceptance leaves `out_valid` low.
- R2: While `out_valid` is high and `out_ready` is low, every output field stays unchanged and no new input is accepted.
- R3: A NaN x (exponent all ones, nonzero fraction) is returned bit-for-bit as a special result. Otherwise a NaN y is returned bit-for-bit.
- R4: The infinity cases are tested in this order, and each result carries the sign of y:
  - x=+inf with y infinite gives pi/4.
  - x=+inf with y finite gives 0.
  - x=-inf with y infinite gives 3pi/4.
  - x=-inf with y finite gives pi.
  - y infinite with x finite gives pi/2.
- R5: The zero cases carry the sign of y:
  - x zero with y nonzero gives pi/2.
  - y zero with x sign bit clear gives 0.
  - y zero with x sign bit set gives pi.
- R6: Subnormal operands behave as finite nonzero values in every case above and in the reduction.
- R7: For finite nonzero operands with |y| < |x| (bits 30:0 compared as unsigned integers), the outputs are:
  - num = y and den = x;
  - negate = 0;
  - offset = +0 when x is positive, or pi with the sign of y when x is negative.
- R8: For finite nonzero operands with |y| >= |x|, the outputs are num = x, den = y, negate = 1, and offset = pi/2 with the sign of y.
- R9: In radian mode (`in_pi_mode`=0) the constant magnitudes are pi 0x40490FDB, pi/2 0x3FC90FDB, pi/4 0x3F490FDB and 3pi/4 0x4016CBE4. In pi mode (`in_pi_mode`=1) they are 0x3F800000, 0x3F000000, 0x3E800000 and 0x3F400000.
- R10: When `out_special` is 1, num, den, offset and negate are all zero. When it is 0, `out_result` is zero.
- R11: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Stage can take an operand pair |
| in_y | input | 32 | y operand (second source) |
| in_x | input | 32 | x operand (first source) |
| in_pi_mode | input | 1 | 1 = result divided by pi, 0 = radians |
| out_valid | output | 1 | Output set present |
| out_ready | input | 1 | Consumer takes the output set |
| out_special | output | 1 | Final result is in out_result |
| out_result | output | 32 | Special-case result |
| out_num | output | 32 | Quotient numerator for the core |
| out_den | output | 32 | Quotient denominator for the core |
| out_offset | output | 32 | Constant added to the arctangent term |
| out_negate | output | 1 | Subtract the arctangent term from the offset |

## Verification
The embedded assertions check the cycle-level properties on every cycle:
- acceptance leads to a valid output;
- outputs are held under back-pressure;
- special outputs carry empty reduction fields;
- the chosen numerator magnitude never exceeds the denominator magnitude;
- a swapped quotient always carries a half-turn offset magnitude.

Only the bench scenarios can show the rest, by comparing against an independent model:
- the exact special-case values;
- the precedence between overlapping NaN, infinity and zero cases;
- the sign taken from y;
- the tie |y| = |x| landing on the swapped form;
- subnormal handling;
- the pi-mode constant substitution.

// File: rtl/atan2_prep_pkg.sv
package atan2_prep_pkg;

  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = FP_W - 1 - EXP_W;
  localparam int MAG_W = FP_W - 1;

  typedef logic [FP_W-1:0] fp_t;

  // operand categories
  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUBN,
    CL_NORM,
    CL_INF,
    CL_NAN
  } fp_cls_e;

  // constant kinds selectable as special result or offset
  typedef enum logic [2:0] {
    K_ZERO,
    K_QTR,
    K_HALF,
    K_3QTR,
    K_FULL
  } k_e;

  // magnitudes, radians
  localparam logic [MAG_W-1:0] RAD_FULL = 31'h40490FDB;
  localparam logic [MAG_W-1:0] RAD_HALF = 31'h3FC90FDB;
  localparam logic [MAG_W-1:0] RAD_QTR  = 31'h3F490FDB;
  localparam logic [MAG_W-1:0] RAD_3QTR = 31'h4016CBE4;
  // magnitudes, turns of pi
  localparam logic [MAG_W-1:0] TRN_FULL = 31'h3F800000;
  localparam logic [MAG_W-1:0] TRN_HALF = 31'h3F000000;
  localparam logic [MAG_W-1:0] TRN_QTR  = 31'h3E800000;
  localparam logic [MAG_W-1:0] TRN_3QTR = 31'h3F400000;

  typedef struct packed {
    logic special;
    fp_t  result;
    fp_t  num;
    fp_t  den;
    fp_t  offset;
    logic negate;
  } prep_t;

endpackage

// File: rtl/atan2_classify.sv
module atan2_classify
  import atan2_prep_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0]   op,
  output fp_cls_e          cls,
  output logic             sign,
  output logic [EW+MW-1:0] mag
);

  localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};

  logic [EW-1:0] ex;
  logic [MW-1:0] fr;

  assign ex   = op[EW+MW-1:MW];
  assign fr   = op[MW-1:0];
  assign sign = op[EW+MW];
  assign mag  = op[EW+MW-1:0];

  always_comb begin
    if (ex == EXP_MAX)      cls = (fr != '0) ? CL_NAN : CL_INF;
    else if (ex == '0)      cls = (fr != '0) ? CL_SUBN : CL_ZERO;
    else                    cls = CL_NORM;
  end

endmodule

// File: rtl/atan2_const_sel.sv
module atan2_const_sel
  import atan2_prep_pkg::*;
(
  input  logic pi_mode,
  input  k_e   kind,
  input  logic sgn,
  output fp_t  value
);

  logic [MAG_W-1:0] mag;

  always_comb begin
    unique case (kind)
      K_QTR:   mag = pi_mode ? TRN_QTR  : RAD_QTR;
      K_HALF:  mag = pi_mode ? TRN_HALF : RAD_HALF;
      K_3QTR:  mag = pi_mode ? TRN_3QTR : RAD_3QTR;
      K_FULL:  mag = pi_mode ? TRN_FULL : RAD_FULL;
      default: mag = '0;
    endcase
  end

  assign value = {sgn, mag};

endmodule

// File: rtl/atan2_case_logic.sv
module atan2_case_logic
  import atan2_prep_pkg::*;
(
  input  fp_t              y_raw,
  input  fp_t              x_raw,
  input  fp_cls_e          y_cls,
  input  fp_cls_e          x_cls,
  input  logic [MAG_W-1:0] y_mag,
  input  logic [MAG_W-1:0] x_mag,
  input  logic             y_sign,
  input  logic             x_sign,
  input  logic             pi_mode,
  output prep_t            prep
);

  logic y_nan, x_nan, y_inf, x_inf, y_zero, x_zero;
  logic is_special, pass_x, pass_y, swap;
  k_e   spec_kind, off_kind;
  logic off_sign;
  fp_t  spec_val, off_val;

  assign y_nan  = (y_cls == CL_NAN);
  assign x_nan  = (x_cls == CL_NAN);
  assign y_inf  = (y_cls == CL_INF);
  assign x_inf  = (x_cls == CL_INF);
  assign y_zero = (y_cls == CL_ZERO);
  assign x_zero = (x_cls == CL_ZERO);

  // precedence chain for special cases
  always_comb begin
    is_special = 1'b1;
    pass_x     = 1'b0;
    pass_y     = 1'b0;
    spec_kind  = K_ZERO;
    if (x_nan)                         pass_x    = 1'b1;
    else if (y_nan)                    pass_y    = 1'b1;
    else if (x_inf && !x_sign && y_inf) spec_kind = K_QTR;
    else if (x_inf && !x_sign)         spec_kind = K_ZERO;
    else if (x_inf && y_inf)           spec_kind = K_3QTR;
    else if (x_inf)                    spec_kind = K_FULL;
    else if (y_inf)                    spec_kind = K_HALF;
    else if (x_zero && !y_zero)        spec_kind = K_HALF;
    else if (y_zero && !x_sign)        spec_kind = K_ZERO;
    else if (y_zero)                   spec_kind = K_FULL;
    else                               is_special = 1'b0;
  end

  // reduction of finite nonzero operands
  always_comb begin
    swap = !(y_mag < x_mag);
    if (swap) begin
      off_kind = K_HALF;
      off_sign = y_sign;
    end else if (x_sign) begin
      off_kind = K_FULL;
      off_sign = y_sign;
    end else begin
      off_kind = K_ZERO;
      off_sign = 1'b0;
    end
  end

  atan2_const_sel u_spec_k (
    .pi_mode (pi_mode),
    .kind    (spec_kind),
    .sgn     (y_sign),
    .value   (spec_val)
  );

  atan2_const_sel u_off_k (
    .pi_mode (pi_mode),
    .kind    (off_kind),
    .sgn     (off_sign),
    .value   (off_val)
  );

  always_comb begin
    prep = '0;
    if (is_special) begin
      prep.special = 1'b1;
      if (pass_x)      prep.result = x_raw;
      else if (pass_y) prep.result = y_raw;
      else             prep.result = spec_val;
    end else begin
      prep.num    = swap ? x_raw : y_raw;
      prep.den    = swap ? y_raw : x_raw;
      prep.offset = off_val;
      prep.negate = swap;
    end
  end

endmodule

// File: rtl/atan2_prep.sv
module atan2_prep
  import atan2_prep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_y,
  input  logic [31:0] in_x,
  input  logic        in_pi_mode,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_special,
  output logic [31:0] out_result,
  output logic [31:0] out_num,
  output logic [31:0] out_den,
  output logic [31:0] out_offset,
  output logic        out_negate
);

  localparam int N_OPS = 2;  // index 0 = y, 1 = x

  fp_t              ops  [N_OPS];
  fp_cls_e          cls  [N_OPS];
  logic             sgn  [N_OPS];
  logic [MAG_W-1:0] mag  [N_OPS];
  prep_t            prep_d, prep_q;
  logic             accept;

  assign ops[0] = in_y;
  assign ops[1] = in_x;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    atan2_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
      .op   (ops[g]),
      .cls  (cls[g]),
      .sign (sgn[g]),
      .mag  (mag[g])
    );
  end

  atan2_case_logic u_case (
    .y_raw   (ops[0]),
    .x_raw   (ops[1]),
    .y_cls   (cls[0]),
    .x_cls   (cls[1]),
    .y_mag   (mag[0]),
    .x_mag   (mag[1]),
    .y_sign  (sgn[0]),
    .x_sign  (sgn[1]),
    .pi_mode (in_pi_mode),
    .prep    (prep_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prep_q    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      prep_q    <= prep_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_special = prep_q.special;
  assign out_result  = prep_q.result;
  assign out_num     = prep_q.num;
  assign out_den     = prep_q.den;
  assign out_offset  = prep_q.offset;
  assign out_negate  = prep_q.negate;

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_num)
      && $stable(out_den) && $stable(out_offset) && $stable(out_negate)
      && $stable(out_special)); // R2

  AST_SPECIAL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_special |-> out_num == '0 && out_den == '0
      && out_offset == '0 && !out_negate); // R10

  AST_RATIO_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_special |-> out_num[MAG_W-1:0] <= out_den[MAG_W-1:0]); // R7

  AST_SWAP_OFFSET: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_special && out_negate |->
      (out_offset[MAG_W-1:0] == RAD_HALF || out_offset[MAG_W-1:0] == TRN_HALF)); // R8

endmodule

// File: tb/atan2_prep_tb_top.sv
`timescale 1ns/1ps
module atan2_prep_tb_top;

  typedef struct packed {
    logic        sp;
    logic [31:0] res;
    logic [31:0] num;
    logic [31:0] den;
    logic [31:0] off;
    logic        neg;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_pi_mode;
  logic [31:0] in_y, in_x;
  logic        out_valid, out_ready, out_special, out_negate;
  logic [31:0] out_result, out_num, out_den, out_offset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  atan2_prep dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_x(in_x), .in_pi_mode(in_pi_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_special(out_special), .out_result(out_result),
    .out_num(out_num), .out_den(out_den),
    .out_offset(out_offset), .out_negate(out_negate)
  );

  function automatic bit is_nan(logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction
  function automatic bit is_inf(logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] == 0;
  endfunction
  function automatic bit is_zero(logic [31:0] v);
    return v[30:0] == 0;
  endfunction

  // idx: 0 = pi, 1 = pi/2, 2 = pi/4, 3 = 3pi/4   (R9)
  function automatic logic [30:0] kmag(logic m, int idx);
    logic [30:0] rad [4];
    logic [30:0] trn [4];
    rad = '{31'h40490FDB, 31'h3FC90FDB, 31'h3F490FDB, 31'h4016CBE4};
    trn = '{31'h3F800000, 31'h3F000000, 31'h3E800000, 31'h3F400000};
    return m ? trn[idx] : rad[idx];
  endfunction

  function automatic exp_t model(logic [31:0] y, logic [31:0] x, logic m);
    exp_t e;
    logic sy;
    e  = '0;
    sy = y[31];
    e.sp = 1'b1;
    if (is_nan(x)) e.res = x;
    else if (is_nan(y)) e.res = y;
    else if (is_inf(x)) begin
      if (!x[31]) e.res = is_inf(y) ? {sy, kmag(m, 2)} : {sy, 31'h0};
      else        e.res = is_inf(y) ? {sy, kmag(m, 3)} : {sy, kmag(m, 0)};
    end
    else if (is_inf(y)) e.res = {sy, kmag(m, 1)};
    else if (is_zero(x) && !is_zero(y)) e.res = {sy, kmag(m, 1)};
    else if (is_zero(y)) e.res = x[31] ? {sy, kmag(m, 0)} : {sy, 31'h0};
    else begin
      e.sp = 1'b0;
      if (y[30:0] < x[30:0]) begin
        e.num = y; e.den = x; e.neg = 1'b0;
        e.off = x[31] ? {sy, kmag(m, 0)} : 32'h0;
      end else begin
        e.num = x; e.den = y; e.neg = 1'b1;
        e.off = {sy, kmag(m, 1)};
      end
    end
    return e;
  endfunction

  function automatic logic [31:0] rnd_op();
    int c;
    logic s;
    c = $urandom_range(0, 9);
    s = $urandom_range(0, 1);
    case (c)
      0: return {s, 31'h0};
      1: return {s, 8'h00, 23'($urandom_range(1, 32'h7FFFFF))};
      2: return {s, 8'hFF, 23'h0};
      3: return {s, 8'hFF, 23'($urandom_range(1, 32'h7FFFFF))};
      default: return {s, 8'($urandom_range(1, 254)), 23'($urandom)};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [160:0] act,
                     input logic [160:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic chk_out(input exp_t e, input string tag);
    exp_t a;
    a = '{out_special, out_result, out_num, out_den, out_offset, out_negate};
    chk(out_valid && a == e, tag, {a}, {e});
  endtask

  task automatic send(input logic [31:0] y, input logic [31:0] x, input logic m,
                      input string tag);
    exp_t e;
    e = model(y, x, m);
    @(negedge clk);
    in_y = y; in_x = x; in_pi_mode = m; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_out(e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t ea, eb;
    logic [31:0] ry, rx;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_y = '0; in_x = '0; in_pi_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(!out_valid && in_ready, "R11", {159'h0, out_valid, in_ready}, {159'h0, 2'b01});

    // R3 NaN precedence
    send(32'h7FC00001, 32'hFFC00123, 1'b0, "R3");
    send(32'h7FA00000, 32'h3F800000, 1'b0, "R3");
    send(32'hFF800001, 32'h7F800000, 1'b1, "R3");
    // R4 infinities
    send(32'hFF800000, 32'h7F800000, 1'b0, "R4");
    send(32'h3F800000, 32'h7F800000, 1'b0, "R4");
    send(32'hC0000000, 32'h7F800000, 1'b0, "R4");
    send(32'h7F800000, 32'hFF800000, 1'b0, "R4");
    send(32'hBF800000, 32'hFF800000, 1'b0, "R4");
    send(32'hFF800000, 32'h80000000, 1'b0, "R4");
    // R5 zeros
    send(32'h80000000, 32'h00000000, 1'b0, "R5");
    send(32'h00000000, 32'h80000000, 1'b0, "R5");
    send(32'h80000000, 32'hC0400000, 1'b0, "R5");
    send(32'h40400000, 32'h80000000, 1'b0, "R5");
    // R6 subnormals
    send(32'h00000001, 32'h00000000, 1'b0, "R6");
    send(32'h80000000, 32'h80000005, 1'b0, "R6");
    send(32'h00000003, 32'h80000007, 1'b0, "R6");
    // R7 and R8 reduction, tie goes to the swapped form
    send(32'h3F000000, 32'h40000000, 1'b0, "R7");
    send(32'hBF000000, 32'hC0000000, 1'b0, "R7");
    send(32'h40000000, 32'h3F000000, 1'b0, "R8");
    send(32'hBF800000, 32'h3F800000, 1'b0, "R8");
    // R9 pi mode constants, R10 field cleanliness
    send(32'h7F800000, 32'hFF800000, 1'b1, "R9");
    send(32'hBF000000, 32'hC0000000, 1'b1, "R9");
    send(32'h40000000, 32'h3F000000, 1'b1, "R10");

    // R1 drain when no new input
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", {159'h0, out_valid, in_ready}, {159'h0, 2'b01});

    // R2 hold under back-pressure
    ea = model(32'h3F000000, 32'hC0000000, 1'b0);
    eb = model(32'h7F800000, 32'h7F800000, 1'b0);
    @(negedge clk);
    in_y = 32'h3F000000; in_x = 32'hC0000000; in_pi_mode = 1'b0;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_y = 32'h7F800000; in_x = 32'h7F800000;
    chk_out(ea, "R1");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!in_ready, "R2", {160'h0, in_ready}, 161'h0);
      chk_out(ea, "R2");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_out(eb, "R2");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      ry = rnd_op();
      rx = rnd_op();
      if ($urandom_range(0, 7) == 0) rx[30:0] = ry[30:0];
      send(ry, rx, 1'($urandom_range(0, 1)), "R7/R8 random");
    end

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule